// File: doc/BRIEF.md
# Buffered-Compare Event Counter

This block counts transitions of an asynchronous event input instead of system clock cycles. The raw input passes through a synchronizer. An edge-select field then decides which of its transitions are counted. Each counted transition advances a counter and reloads a shadow copy of a software-written compare value. When the counter already holds the shadowed value at a counted transition, it returns to zero and emits a one-cycle interrupt pulse. The interval between interrupts is therefore one more than the compare value, measured in counted transitions.

Counting needs two conditions: the enable bit must be set and the mode field must select event counting. Each time that combined run condition becomes true, the counter is preset to all ones and the shadow is loaded, so the first counted transition brings the counter to zero. While not running, the counter holds its value and events are ignored.

Top module: `evt_counter`

## Requirements
- R1: After reset the counter reads 0, the compare register and its shadow hold 0, and the interrupt is low.
- R2: In the cycle after the run condition (enable bit 1 and mode field 3'b001) becomes true, the counter reads all ones, and the shadow holds the compare register value.
- R3: The counter changes only on a counted event transition or at the start of a run, and never advances on system clock cycles alone.
- R4: The edge-select field encodes 2'b00 as no transition counted, 2'b01 as rising only, 2'b10 as falling only and 2'b11 as both directions.
- R5: The event input passes through a two-stage synchronizer. A level held for any number of cycles is counted at most once.
- R6: Every counted transition copies the compare register into the shadow. A write to the compare register is used only from the counted transition after the next one, so a match that the present shadow already sets up still occurs.
- R7: At a counted transition where the counter equals the shadow, the counter becomes 0 and the interrupt is high for exactly that one cycle. At other times the interrupt is low.
- R8: With compare value C held constant from the start of a run, the first interrupt comes on counted transition C+2, or on transition 1 when C is all ones. Each later interrupt comes C+1 counted transitions after the one before.
- R9: While the run condition is false, the counter and shadow hold their values, no interrupt is raised, and event transitions are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_in | input | 1 | Raw asynchronous event input |
| cnt_en | input | 1 | Count enable bit |
| mode | input | 3 | Operating mode; 3'b001 selects event counting |
| edge_sel | input | 2 | Selects which event transitions are counted |
| cmp_we | input | 1 | Compare register write strobe |
| cmp_wdata | input | CW | Compare register write data |
| count | output | CW | Counter readback |
| cmp_irq | output | 1 | One-cycle compare-match interrupt |

## Verification
The bench builds the counter with CW = 4. This makes every compare value from 0 to the all-ones value reachable in a few dozen transitions. The bench sweeps all sixteen compare values and checks the first and second interrupt positions against the arithmetic formula, including the all-ones case where the preset value matches at once. It also covers all four edge-select codes, one long held level, a compare write made while a match is pending, and stimulus given while the mode field or the enable bit blocks counting.

// File: rtl/evt_counter.sv
module evt_counter #(
  parameter int CW   = 16,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt_in,
  input  logic          cnt_en,
  input  logic [2:0]    mode,
  input  logic [1:0]    edge_sel,
  input  logic          cmp_we,
  input  logic [CW-1:0] cmp_wdata,
  output logic [CW-1:0] count,
  output logic          cmp_irq
);

  localparam logic [2:0]    RUN_MODE = 3'b001;
  localparam logic [CW-1:0] ALL_ONES = {CW{1'b1}};

  logic [SYNC-1:0] sync_q;
  logic            evt_prev;
  logic            evt_s;
  logic            rise, fall, vedge;
  logic            run, run_q, start, step;
  logic [CW-1:0]   cmp_reg, cmp_buf, cnt_q;
  logic            irq_q;

  assign evt_s = sync_q[SYNC-1];
  assign rise  = evt_s & ~evt_prev;
  assign fall  = ~evt_s & evt_prev;

  always_comb begin
    case (edge_sel)
      2'b01:   vedge = rise;
      2'b10:   vedge = fall;
      2'b11:   vedge = rise | fall;
      default: vedge = 1'b0;
    endcase
  end

  assign run   = cnt_en && (mode == RUN_MODE);
  assign start = run && !run_q;
  assign step  = run && !start && vedge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= '0;
      evt_prev <= 1'b0;
      run_q    <= 1'b0;
    end else begin
      sync_q   <= {sync_q[SYNC-2:0], evt_in};
      evt_prev <= evt_s;
      run_q    <= run;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmp_reg <= '0;
    else if (cmp_we) cmp_reg <= cmp_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      cmp_buf <= '0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (start) begin
        cnt_q   <= ALL_ONES;
        cmp_buf <= cmp_reg;
      end else if (step) begin
        cmp_buf <= cmp_reg;
        if (cnt_q == cmp_buf) begin
          cnt_q <= '0;
          irq_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign count   = cnt_q;
  assign cmp_irq = irq_q;

  // R2
  preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !run_q) |=> (count == ALL_ONES));

  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(run && (run_q ? vedge : 1'b1)) |=> $stable(count));

  // R6
  buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(run && (vedge || !run_q)) |=> $stable(cmp_buf));

  // R7
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_irq |-> (count == '0));

  // R9
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!cmp_irq && $stable(count)));

endmodule

// File: tb/evt_counter_tb.sv
module evt_counter_tb;
  localparam int CLK_P = 10;
  localparam int CW    = 4;
  localparam logic [CW-1:0] MAXV = {CW{1'b1}};

  logic clk = 0, rst_n = 0, evt_in = 0, cnt_en = 0, cmp_we = 0;
  logic [2:0] mode = 3'b000;
  logic [1:0] edge_sel = 2'b01;
  logic [CW-1:0] cmp_wdata = '0;
  logic [CW-1:0] count;
  logic cmp_irq;

  int checks = 0, fails = 0, irq_cnt = 0;
  bit done = 0;

  evt_counter #(.CW(CW), .SYNC(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .cnt_en(cnt_en), .mode(mode),
    .edge_sel(edge_sel), .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
    .count(count), .cmp_irq(cmp_irq));

  always #(CLK_P/2) clk = ~clk;

  always @(negedge clk) if (cmp_irq) irq_cnt++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_evt(input logic v);
    @(negedge clk) evt_in = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse();
    set_evt(1'b1);
    set_evt(1'b0);
  endtask

  task automatic begin_run(input logic [CW-1:0] c, input logic [1:0] sel);
    @(negedge clk) begin cnt_en = 0; cmp_we = 1; cmp_wdata = c; edge_sel = sel; mode = 3'b001; end
    @(negedge clk) begin cmp_we = 0; cnt_en = 1; end
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int base, first, second, exp_first, exp_second, prev;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 count", count, 0);
    chk("R1 irq", cmp_irq, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R2 preset on start
    begin_run(4'd5, 2'b01);
    chk("R2 preset", count, MAXV);
    // R3 no advance on clock alone
    repeat (20) @(negedge clk);
    chk("R3 idle clocks", count, MAXV);

    // R4 edge select sweep, three pulses each
    for (int s = 0; s < 4; s++) begin
      int n;
      begin_run(4'd14, s[1:0]);
      base = irq_cnt;
      for (int p = 0; p < 3; p++) pulse();
      n = (s == 0) ? 0 : (s == 3) ? 6 : 3;
      chk("R4 edge code count", count, (n == 0) ? MAXV : n - 1);
      chk("R4 no irq", irq_cnt - base, 0);
    end

    // R5 long held level counted once
    begin_run(4'd14, 2'b11);
    @(negedge clk) evt_in = 1;
    repeat (30) @(negedge clk);
    chk("R5 held level", count, 0);
    @(negedge clk) evt_in = 0;
    repeat (30) @(negedge clk);
    chk("R5 held low", count, 1);

    // R8 sweep all compare values, R7 clear and pulse width
    for (int c = 0; c <= MAXV; c++) begin
      begin_run(c[CW-1:0], 2'b01);
      exp_first  = (c == MAXV) ? 1 : c + 2;
      exp_second = exp_first + c + 1;
      first = 0; second = 0;
      for (int k = 1; k <= exp_second + 1; k++) begin
        prev = irq_cnt;
        pulse();
        if (irq_cnt != prev) begin
          chk("R7 pulse width", irq_cnt - prev, 1);
          chk("R7 cleared", count, 0);
          if (first == 0) first = k;
          else if (second == 0) second = k;
        end
      end
      chk("R8 first irq edge", first, exp_first);
      chk("R8 second irq edge", second, exp_second);
    end

    // R6 write while a match is pending
    begin_run(4'd3, 2'b01);
    for (int k = 0; k < 4; k++) pulse();
    chk("R6 pre-write count", count, 3);
    @(negedge clk) begin cmp_we = 1; cmp_wdata = 4'd9; end
    @(negedge clk) cmp_we = 0;
    base = irq_cnt;
    pulse();
    chk("R6 pending match kept", irq_cnt - base, 1);
    chk("R6 cleared", count, 0);
    for (int k = 0; k < 9; k++) pulse();
    chk("R6 no early irq", irq_cnt - base, 1);
    chk("R6 count at new limit", count, 9);
    pulse();
    chk("R6 new value used", irq_cnt - base, 2);

    // R9 wrong mode and enable low ignore events
    begin_run(4'd14, 2'b11);
    pulse();
    chk("R9 running", count, 1);
    @(negedge clk) mode = 3'b010;
    base = irq_cnt;
    for (int k = 0; k < 20; k++) pulse();
    chk("R9 mode hold", count, 1);
    @(negedge clk) begin mode = 3'b001; cnt_en = 0; end
    for (int k = 0; k < 20; k++) pulse();
    chk("R9 enable hold", count, 1);
    chk("R9 no irq", irq_cnt - base, 0);
    @(negedge clk) cnt_en = 1;
    repeat (2) @(negedge clk);
    chk("R2 restart preset", count, MAXV);

    finish_run();
  end
endmodule